// File: doc/BRIEF.md
# Cache Error Syndrome Logger

This block gathers error events from the checkers around a shared cache and turns them into two software-readable syndrome words and one interrupt line. Uncorrectable events come from the cache data, cache tag and snoop-filter tag double-bit ECC checkers and from the bus slave-error path. Byte-parity events arrive on their own port and carry an address, a requester source ID and an operation class. Corrected single-bit ECC events drive a separate counter that remembers the type and set of the errors it has counted.

The first uncorrectable or parity event is captured as a record and raises the interrupt. Any later event that arrives while that record is held only sets a sticky multiple-errors flag, so the record always describes the oldest unserviced fault. Software reads the two words through a word select, then writes a clear word with one bit per flag to release the record. A global enable input masks all logging.

Top module: `err_syndrome_logger`

## Requirements
- R1: After reset both syndrome words read zero and `irq` is low.
- R2: An uncorrectable event with code 100 (cache data), 101 (cache tag) or 110 (snoop-filter tag) sets first-valid (word 0 bit 62), stores the code in word 0 bits [2:0], clears the parity flag (word 0 bit 3) and stores the address in word 1 bits [43:0]. Code 111 (bus slave error) is logged the same way but its address field reads zero. Codes with bit 2 clear are ignored.
- R3: A parity event sets first-valid and the parity flag, stores code 000, the address in word 1 [43:0], the source ID in word 1 [54:48] and the operation class in word 1 [45:44] (00 write-unique, 01 partial writeback, 10 non-snooping write, 11 other). Source ID and class read zero after an uncorrectable capture.
- R4: While first-valid is set, a new uncorrectable or parity event sets the multiple-errors flag (word 0 bit 59) and leaves the stored record unchanged.
- R5: When an uncorrectable and a parity event arrive in the same cycle with no record held, the uncorrectable event is captured and the multiple-errors flag is set.
- R6: A clear write with bit 62 set clears first-valid; bit 59 set clears the multiple-errors flag; all other clear bits have no effect. An event in the same cycle as a clear of first-valid is captured as a fresh record.
- R7: Each corrected event (type 00 cache data, 01 cache tag, 10 snoop-filter tag) increments the 16-bit count in word 0 [58:43]; the first one after reset stores its type in word 0 [5:4], its 12-bit set in word 0 [19:8] and sets the match flag (word 0 bit 6).
- R8: A corrected event whose type or set differs from the stored ones clears the match flag and replaces the stored type and set; the match flag stays clear afterwards.
- R9: At a count of 0xFFFF the counter holds, and the next corrected event sets the sticky overflow flag (word 0 bit 7).
- R10: A corrected event with type 11 is ignored.
- R11: While `report_en` is low all events are ignored and `irq` is low; while it is high `irq` follows first-valid.
- R12: Corrected events never set first-valid, the multiple-errors flag or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| report_en | input | 1 | Global logging and interrupt enable |
| ue_valid | input | 1 | Uncorrectable event strobe |
| ue_code | input | 3 | Uncorrectable event code |
| ue_addr | input | 44 | Address of the uncorrectable event |
| par_valid | input | 1 | Byte-parity event strobe |
| par_addr | input | 44 | Address of the parity event |
| par_srcid | input | 7 | Requester source ID of the parity event |
| par_optype | input | 2 | Operation class of the parity event |
| ce_valid | input | 1 | Corrected single-bit event strobe |
| ce_type | input | 2 | Corrected event array type |
| ce_set | input | 12 | Corrected event set address |
| clr_wr | input | 1 | Clear-word write strobe |
| clr_data | input | 64 | Clear word, one bit per flag |
| rd_sel | input | 1 | Syndrome word select (0 or 1) |
| rd_data | output | 64 | Selected syndrome word |
| irq | output | 1 | Error interrupt |

## Verification
The assertions check on every cycle that a held record neither moves nor drops without a clear, that the multiple-errors and overflow flags stay set, that the counter steps by one or sits saturated, that type-11 corrected events leave it still, and that masked cycles leave first-valid alone. Only the bench scenarios can show the field positions and code values seen by software, the same-cycle priority between the two uncorrectable sources and between an event and a clear, the zeroed address for slave errors, and the match flag following type and set changes across a sequence of corrected events.

// File: rtl/esl_pkg.sv
package esl_pkg;
   // Syndrome word 0 bit positions (software decodes these)
   localparam int W0_FIRST   = 62;
   localparam int W0_MULT    = 59;
   localparam int W0_CNT_LO  = 43;
   localparam int W0_SET_LO  = 8;
   localparam int W0_OVF     = 7;
   localparam int W0_MATCH   = 6;
   localparam int W0_TYPE_LO = 4;
   localparam int W0_PAR     = 3;
   // Syndrome word 1 bit positions
   localparam int W1_SRC_LO  = 48;
   localparam int W1_OP_LO   = 44;
   // Field width ceilings implied by the layout
   localparam int MAX_ADDR_W = 44;
   localparam int MAX_SRC_W  = 7;
   localparam int MAX_SET_W  = 12;
   localparam int MAX_CNT_W  = 16;

   typedef enum logic [2:0] {
      UE_NONE     = 3'b000,
      UE_DATA_DBE = 3'b100,
      UE_TAG_DBE  = 3'b101,
      UE_SF_DBE   = 3'b110,
      UE_SLV_ERR  = 3'b111
   } ue_code_e;

   typedef enum logic [1:0] {
      CE_DATA = 2'b00,
      CE_TAG  = 2'b01,
      CE_SF   = 2'b10,
      CE_BAD  = 2'b11
   } ce_type_e;
endpackage

// File: rtl/esl_first_rec.sv
module esl_first_rec
   import esl_pkg::*;
#(
   parameter int ADDR_W = 44,
   parameter int SRC_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ue_valid,
   input  logic [2:0]        ue_code,
   input  logic [ADDR_W-1:0] ue_addr,
   input  logic              par_valid,
   input  logic [ADDR_W-1:0] par_addr,
   input  logic [SRC_W-1:0]  par_srcid,
   input  logic [1:0]        par_optype,
   input  logic              clr_first,
   input  logic              clr_mult,
   output logic              rec_vld,
   output logic              rec_mult,
   output logic [2:0]        rec_code,
   output logic              rec_par,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [SRC_W-1:0]  rec_srcid,
   output logic [1:0]        rec_optype
);
   logic ue_ok, par_ok, held, any_ev, both_ev, capture;

   always_comb begin
      ue_ok   = en & ue_valid & ue_code[2];
      par_ok  = en & par_valid;
      held    = rec_vld & ~clr_first;
      any_ev  = ue_ok | par_ok;
      both_ev = ue_ok & par_ok;
      capture = any_ev & ~held;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_vld    <= 1'b0;
         rec_mult   <= 1'b0;
         rec_code   <= UE_NONE;
         rec_par    <= 1'b0;
         rec_addr   <= '0;
         rec_srcid  <= '0;
         rec_optype <= '0;
      end else begin
         rec_vld  <= held | any_ev;
         rec_mult <= (rec_mult & ~clr_mult) | (any_ev & held) | (both_ev & ~held);
         if (capture) begin
            if (ue_ok) begin
               rec_code   <= ue_code;
               rec_par    <= 1'b0;
               rec_addr   <= (ue_code == UE_SLV_ERR) ? '0 : ue_addr;
               rec_srcid  <= '0;
               rec_optype <= '0;
            end else begin
               rec_code   <= UE_NONE;
               rec_par    <= 1'b1;
               rec_addr   <= par_addr;
               rec_srcid  <= par_srcid;
               rec_optype <= par_optype;
            end
         end
      end
   end

   // R4: a held record stays put until software clears it
   a_r4_record_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_vld && !clr_first) |=> (rec_vld && $stable(rec_addr) && $stable(rec_code) && $stable(rec_par)));

   // R4: the multiple-errors flag is sticky without a clear
   a_r4_mult_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_mult && !clr_mult) |=> rec_mult);

   // R6: a clear with no event drops first-valid
   a_r6_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_first && !ue_valid && !par_valid) |=> !rec_vld);
endmodule

// File: rtl/esl_ce_count.sv
module esl_ce_count
   import esl_pkg::*;
#(
   parameter int SET_W = 12,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ce_valid,
   input  logic [1:0]       ce_type,
   input  logic [SET_W-1:0] ce_set,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf,
   output logic             match,
   output logic [1:0]       cnt_type,
   output logic [SET_W-1:0] cnt_set
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic ok, fresh, at_max, same;

   always_comb begin
      ok     = en & ce_valid & (ce_type != CE_BAD);
      fresh  = (cnt == '0) & ~ovf;
      at_max = (cnt == CNT_MAX);
      same   = (cnt_type == ce_type) & (cnt_set == ce_set);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         ovf      <= 1'b0;
         match    <= 1'b0;
         cnt_type <= CE_DATA;
         cnt_set  <= '0;
      end else if (ok) begin
         if (at_max) ovf <= 1'b1;
         else        cnt <= cnt + 1'b1;
         if (fresh) begin
            match    <= 1'b1;
            cnt_type <= ce_type;
            cnt_set  <= ce_set;
         end else if (!same) begin
            match    <= 1'b0;
            cnt_type <= ce_type;
            cnt_set  <= ce_set;
         end
      end
   end

   // R7: an accepted event below the ceiling steps the count by one
   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ce_valid && ce_type != CE_BAD && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

   // R9: at the ceiling the count holds and overflow rises
   a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ce_valid && ce_type != CE_BAD && cnt == CNT_MAX) |=> (cnt == CNT_MAX && ovf));

   // R9: overflow is sticky
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   // R10: type 11 leaves the counter untouched
   a_r10_bad_type: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_valid && ce_type == CE_BAD) |=> ($stable(cnt) && $stable(match)));
endmodule

// File: rtl/err_syndrome_logger.sv
module err_syndrome_logger
   import esl_pkg::*;
#(
   parameter int ADDR_W  = 44,
   parameter int SRC_W   = 7,
   parameter int SET_W   = 12,
   parameter int CNT_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              report_en,
   input  logic              ue_valid,
   input  logic [2:0]        ue_code,
   input  logic [ADDR_W-1:0] ue_addr,
   input  logic              par_valid,
   input  logic [ADDR_W-1:0] par_addr,
   input  logic [SRC_W-1:0]  par_srcid,
   input  logic [1:0]        par_optype,
   input  logic              ce_valid,
   input  logic [1:0]        ce_type,
   input  logic [SET_W-1:0]  ce_set,
   input  logic              clr_wr,
   input  logic [63:0]       clr_data,
   input  logic              rd_sel,
   output logic [63:0]       rd_data,
   output logic              irq
);
   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr
      $error("ADDR_W out of range for the syndrome layout");
   end
   if (SRC_W < 1 || SRC_W > MAX_SRC_W) begin : g_bad_src
      $error("SRC_W out of range for the syndrome layout");
   end
   if (SET_W < 1 || SET_W > MAX_SET_W) begin : g_bad_set
      $error("SET_W out of range for the syndrome layout");
   end
   if (CNT_W < 2 || CNT_W > MAX_CNT_W) begin : g_bad_cnt
      $error("CNT_W out of range for the syndrome layout");
   end

   logic              clr_first, clr_mult;
   logic              rec_vld, rec_mult, rec_par;
   logic [2:0]        rec_code;
   logic [ADDR_W-1:0] rec_addr;
   logic [SRC_W-1:0]  rec_srcid;
   logic [1:0]        rec_optype;
   logic [CNT_W-1:0]  cnt;
   logic              ovf, match;
   logic [1:0]        cnt_type;
   logic [SET_W-1:0]  cnt_set;
   logic [63:0]       word0, word1;

   assign clr_first = clr_wr & clr_data[W0_FIRST];
   assign clr_mult  = clr_wr & clr_data[W0_MULT];

   esl_first_rec #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_rec (
      .clk(clk), .rst_n(rst_n), .en(report_en),
      .ue_valid(ue_valid), .ue_code(ue_code), .ue_addr(ue_addr),
      .par_valid(par_valid), .par_addr(par_addr),
      .par_srcid(par_srcid), .par_optype(par_optype),
      .clr_first(clr_first), .clr_mult(clr_mult),
      .rec_vld(rec_vld), .rec_mult(rec_mult), .rec_code(rec_code),
      .rec_par(rec_par), .rec_addr(rec_addr),
      .rec_srcid(rec_srcid), .rec_optype(rec_optype)
   );

   esl_ce_count #(.SET_W(SET_W), .CNT_W(CNT_W)) u_ce (
      .clk(clk), .rst_n(rst_n), .en(report_en),
      .ce_valid(ce_valid), .ce_type(ce_type), .ce_set(ce_set),
      .cnt(cnt), .ovf(ovf), .match(match),
      .cnt_type(cnt_type), .cnt_set(cnt_set)
   );

   always_comb begin
      word0 = '0;
      word0[W0_FIRST]              = rec_vld;
      word0[W0_MULT]               = rec_mult;
      word0[W0_CNT_LO +: CNT_W]    = cnt;
      word0[W0_SET_LO +: SET_W]    = cnt_set;
      word0[W0_OVF]                = ovf;
      word0[W0_MATCH]              = match;
      word0[W0_TYPE_LO +: 2]       = cnt_type;
      word0[W0_PAR]                = rec_par;
      word0[2:0]                   = rec_code;
      word1 = '0;
      word1[W1_SRC_LO +: SRC_W]    = rec_srcid;
      word1[W1_OP_LO +: 2]         = rec_optype;
      word1[ADDR_W-1:0]            = rec_addr;
      rd_data = rd_sel ? word1 : word0;
   end

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= rec_vld & report_en;
      end
   end else begin : g_irq_comb
      assign irq = rec_vld & report_en;
   end

   // R11: masked cycles without a clear cannot raise first-valid
   a_r11_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!report_en && !clr_wr && !rec_vld) |=> !rec_vld);

   // R12: corrected events alone never raise first-valid
   a_r12_ce_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (!ue_valid && !par_valid && !rec_vld) |=> !rec_vld);
endmodule

// File: tb/err_syndrome_logger_tb_top.sv
module err_syndrome_logger_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        report_en = 1'b1;
   logic        ue_valid = 1'b0;
   logic [2:0]  ue_code = 3'b000;
   logic [43:0] ue_addr = '0;
   logic        par_valid = 1'b0;
   logic [43:0] par_addr = '0;
   logic [6:0]  par_srcid = '0;
   logic [1:0]  par_optype = '0;
   logic        ce_valid = 1'b0;
   logic [1:0]  ce_type = '0;
   logic [11:0] ce_set = '0;
   logic        clr_wr = 1'b0;
   logic [63:0] clr_data = '0;
   logic        rd_sel = 1'b0;
   logic [63:0] rd_data;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   err_syndrome_logger dut_i (
      .clk(clk), .rst_n(rst_n), .report_en(report_en),
      .ue_valid(ue_valid), .ue_code(ue_code), .ue_addr(ue_addr),
      .par_valid(par_valid), .par_addr(par_addr),
      .par_srcid(par_srcid), .par_optype(par_optype),
      .ce_valid(ce_valid), .ce_type(ce_type), .ce_set(ce_set),
      .clr_wr(clr_wr), .clr_data(clr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [63:0] d);
      rd_sel = sel;
      #1;
      d = rd_data;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      report_en = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_ue(input logic [2:0] c, input logic [43:0] a);
      ue_valid = 1'b1; ue_code = c; ue_addr = a;
      @(negedge clk);
      ue_valid = 1'b0;
   endtask

   task automatic pulse_par(input logic [43:0] a, input logic [6:0] s, input logic [1:0] o);
      par_valid = 1'b1; par_addr = a; par_srcid = s; par_optype = o;
      @(negedge clk);
      par_valid = 1'b0;
   endtask

   task automatic pulse_ce(input logic [1:0] t, input logic [11:0] s);
      ce_valid = 1'b1; ce_type = t; ce_set = s;
      @(negedge clk);
      ce_valid = 1'b0;
   endtask

   task automatic pulse_clr(input logic [63:0] d);
      clr_wr = 1'b1; clr_data = d;
      @(negedge clk);
      clr_wr = 1'b0;
   endtask

   task automatic t_reset();
      logic [63:0] w;
      do_reset();
      rd(0, w); check("R1 word0", w, 64'h0);
      rd(1, w); check("R1 word1", w, 64'h0);
      check("R1 irq", {63'h0, irq}, 64'h0);
   endtask

   task automatic t_ue_capture();
      logic [63:0] w;
      do_reset();
      pulse_ue(3'b101, 44'hABC_1234_5678);
      rd(0, w); check("R2 word0 tag dbe", w, (64'h1 << 62) | 64'h5);
      rd(1, w); check("R2 word1 addr", w, 64'h0ABC_1234_5678);
      check("R11 irq follows first-valid", {63'h0, irq}, 64'h1);
      pulse_clr(64'h1 << 62);
      pulse_ue(3'b111, 44'h123_4567_89AB);
      rd(0, w); check("R2 slave error code", w, (64'h1 << 62) | 64'h7);
      rd(1, w); check("R2 slave error addr zero", w, 64'h0);
      pulse_clr(64'h1 << 62);
      pulse_ue(3'b011, 44'h111);
      rd(0, w); check("R2 low code ignored", w & (64'h1 << 62), 64'h0);
   endtask

   task automatic t_par_capture();
      logic [63:0] w;
      do_reset();
      pulse_par(44'h0F0_0000_0040, 7'h5A, 2'b01);
      rd(0, w); check("R3 word0 parity", w, (64'h1 << 62) | 64'h8);
      rd(1, w); check("R3 word1 fields", w, (64'h5A << 48) | (64'h1 << 44) | 64'h0F0_0000_0040);
   endtask

   task automatic t_multi();
      logic [63:0] w;
      do_reset();
      pulse_ue(3'b100, 44'h100);
      pulse_par(44'h200, 7'h11, 2'b10);
      pulse_ue(3'b110, 44'h300);
      rd(0, w); check("R4 mult set record kept", w, (64'h1 << 62) | (64'h1 << 59) | 64'h4);
      rd(1, w); check("R4 address kept", w, 64'h100);
   endtask

   task automatic t_simul();
      logic [63:0] w;
      do_reset();
      ue_valid = 1'b1; ue_code = 3'b110; ue_addr = 44'h777;
      par_valid = 1'b1; par_addr = 44'h888; par_srcid = 7'h3; par_optype = 2'b11;
      @(negedge clk);
      ue_valid = 1'b0; par_valid = 1'b0;
      rd(0, w); check("R5 uncorrectable wins with mult", w, (64'h1 << 62) | (64'h1 << 59) | 64'h6);
      rd(1, w); check("R5 uncorrectable address", w, 64'h777);
   endtask

   task automatic t_clear();
      logic [63:0] w;
      do_reset();
      pulse_ue(3'b100, 44'h10);
      pulse_ue(3'b100, 44'h20);
      pulse_clr(~((64'h1 << 62) | (64'h1 << 59)));
      rd(0, w); check("R6 other clear bits no effect", w, (64'h1 << 62) | (64'h1 << 59) | 64'h4);
      pulse_clr(64'h1 << 59);
      rd(0, w); check("R6 mult clear only", w, (64'h1 << 62) | 64'h4);
      pulse_clr(64'h1 << 62);
      rd(0, w); check("R6 first clear", w & ((64'h1 << 62) | (64'h1 << 59)), 64'h0);
      check("R6 irq drops", {63'h0, irq}, 64'h0);
      pulse_ue(3'b100, 44'h30);
      clr_wr = 1'b1; clr_data = 64'h1 << 62;
      ue_valid = 1'b1; ue_code = 3'b101; ue_addr = 44'h40;
      @(negedge clk);
      clr_wr = 1'b0; ue_valid = 1'b0;
      rd(0, w); check("R6 event beside clear is fresh", w, (64'h1 << 62) | 64'h5);
      rd(1, w); check("R6 fresh address", w, 64'h40);
   endtask

   task automatic t_ce_match();
      logic [63:0] w;
      do_reset();
      pulse_ce(2'b01, 12'hA5C);
      pulse_ce(2'b01, 12'hA5C);
      rd(0, w); check("R7 count type set match", w,
                      (64'd2 << 43) | (64'hA5C << 8) | (64'h1 << 6) | (64'h1 << 4));
      check("R12 no irq from corrected", {63'h0, irq}, 64'h0);
      pulse_ce(2'b01, 12'h003);
      rd(0, w); check("R8 set change clears match", w, (64'd3 << 43) | (64'h003 << 8) | (64'h1 << 4));
      pulse_ce(2'b01, 12'h003);
      rd(0, w); check("R8 match stays clear", w, (64'd4 << 43) | (64'h003 << 8) | (64'h1 << 4));
      pulse_ce(2'b10, 12'h003);
      rd(0, w); check("R8 type change updates", w, (64'd5 << 43) | (64'h003 << 8) | (64'h2 << 4));
      pulse_ce(2'b11, 12'hFFF);
      rd(0, w); check("R10 type 11 ignored", w, (64'd5 << 43) | (64'h003 << 8) | (64'h2 << 4));
   endtask

   task automatic t_mask();
      logic [63:0] w;
      do_reset();
      report_en = 1'b0;
      pulse_ue(3'b100, 44'h55);
      pulse_par(44'h66, 7'h1, 2'b00);
      pulse_ce(2'b00, 12'h1);
      rd(0, w); check("R11 masked events ignored", w, 64'h0);
      report_en = 1'b1;
      pulse_ue(3'b100, 44'h55);
      check("R11 irq with enable", {63'h0, irq}, 64'h1);
      report_en = 1'b0;
      #1;
      check("R11 irq masked", {63'h0, irq}, 64'h0);
      report_en = 1'b1;
   endtask

   task automatic t_saturate();
      logic [63:0] w;
      do_reset();
      ce_valid = 1'b1; ce_type = 2'b00; ce_set = 12'h7E1;
      repeat (65535) @(negedge clk);
      ce_valid = 1'b0;
      rd(0, w); check("R9 count at ceiling", w, (64'hFFFF << 43) | (64'h7E1 << 8) | (64'h1 << 6));
      pulse_ce(2'b00, 12'h7E1);
      rd(0, w); check("R9 holds and overflows", w,
                      (64'hFFFF << 43) | (64'h7E1 << 8) | (64'h1 << 7) | (64'h1 << 6));
   endtask

   initial begin
      t_reset();
      t_ue_capture();
      t_par_capture();
      t_multi();
      t_simul();
      t_clear();
      t_ce_match();
      t_mask();
      t_saturate();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule